// File: doc/BRIEF.md
# TE-Synchronised Serial Frame Transmitter

This block is a serial master for small display panels. It has two modes. In command mode it behaves like a plain SPI master. A start pulse sends a short list of configuration words of a programmable length, most significant bit first, on a single data wire. In frame mode it waits for a rising edge on the panel's tearing-effect input. It then streams one whole frame of 16-bit RGB565 pixels, taken from a valid/ready pixel stream, on one or two data wires.

Chip select stays low for the whole burst. A programmable number of lead serial clocks comes before the first bit, and a programmable number of idle serial clocks sits between successive words. The serial clock runs at half the system clock. Every bit occupies two system cycles, with sclk low in the first and high in the second, and the panel samples on the rising sclk edge. To keep a frame inside one tearing interval, the serial clock must be faster than pixels × 16 × frame rate, divided by two when two wires are used. Fetching pixels from memory and synthesising the clock are handled outside the block.

Top module: `te_frame_serializer`

## Requirements
- R1: After reset and whenever no burst is active: cs_n=1, sclk=0, sdo=2'b00, busy=0, pix_ready=0.
- R2: In command mode (te_mode=0), a cmd_start pulse sends the words in cmd_words, word i taken from bits [16i+15:16i]. Each word sends its low L bits, MSB first, one bit per sclk high cycle on sdo[0], with sdo[1]=0. In a 9-bit word, bit 8 is the data/command flag and goes out first (0 marks a command such as 0x0DA, 1 marks a parameter such as 0x1FF). sdo does not change during an sclk high cycle, and sclk is never high for two cycles in a row.
- R3: L equals word_bits for values 1..16. A word_bits value of 0, or a value above 16, gives 16-bit words.
- R4: A cmd_start with cmd_count=0 starts no burst. A cmd_count above 8 sends exactly 8 words.
- R5: With lead_cycles=D, the first sclk high cycle is exactly 2D+2 system cycles after the cycle in which cs_n falls. sclk is low when cs_n falls.
- R6: Inside a word, sclk high cycles are 2 cycles apart. With gap_cycles=W, the last sclk high cycle of one word and the first of the next are 2W+3 cycles apart.
- R7: cs_n stays low throughout a burst. It rises exactly 3 cycles after the final sclk high cycle, and sclk is low in the two cycles before it rises.
- R8: In frame mode (te_mode=1), cmd_start has no effect. A frame starts only after a rising edge on te_in, and a te_in level held high starts nothing further.
- R9: A frame is FRAME_PIXELS pixels, each taken by a pix_valid/pix_ready handshake. In single-wire mode (dual_lane=0) each pixel is 16 bits, MSB first, on sdo[0], with sdo[1]=0. The cycle after a handshake, cs_n is low and sclk is low.
- R10: In dual-wire mode (dual_lane=1), a pixel takes 8 sclk cycles. In slot k (k=0..7), sdo[1] carries pixel bit 15-2k and sdo[0] carries bit 14-2k.
- R11: A rising te_in edge that arrives while a frame is being sent is ignored, and no second frame follows.
- R12: If pix_valid is low when the next pixel is due, sclk stays low and cs_n stays low until a pixel arrives. No pixel is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| te_mode | input | 1 | 1 = frame mode gated by tearing edge, 0 = command mode |
| dual_lane | input | 1 | Frame mode: 1 = two data wires, 0 = one |
| word_bits | input | 5 | Command word length in bits |
| lead_cycles | input | CNT_W | Serial clocks between cs_n falling and the first bit |
| gap_cycles | input | CNT_W | Idle serial clocks between words |
| cmd_words | input | MAX_WORDS*16 | Command word buffer, word i at bits [16i+15:16i] |
| cmd_count | input | QW | Number of command words to send |
| cmd_start | input | 1 | Single-cycle start request in command mode |
| te_in | input | 1 | Tearing-effect input from the panel (asynchronous) |
| pix_data | input | 16 | RGB565 pixel from the stream |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Block takes a pixel when this and pix_valid are both high |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 2 | Serial data, wire 0 and wire 1 |
| busy | output | 1 | A burst is in progress |

## Verification
The assertions check on every cycle that the lines are quiet while cs_n is high, and that sclk is a single-cycle pulse with sdo steady across it. They also check that chip select opens and closes with sclk low, and that a pixel handshake is followed by a low-clock setup cycle. Other behaviour can only be shown by the directed scenarios, which decode the serial stream against expected words and pixels. These include word-length and word-count clamping, the exact lead and gap spacing, the even/odd bit split across two wires, stalls in the pixel stream, and the rejection of cmd_start and of tearing edges that arrive mid-frame.

// File: rtl/tfs_pkg.sv
`timescale 1ns/1ps
package tfs_pkg;

    localparam int WORD_MAX = 16;
    localparam int LEN_W    = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_FETCH,
        S_SHIFT,
        S_GAP,
        S_TAIL
    } tfs_state_e;

    typedef struct packed {
        logic             frame;
        logic             dual;
        logic [LEN_W-1:0] len;
    } tfs_xfer_t;

    // Effective word length: 1..16 as given, anything else means 16.
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] wb);
        if (wb == '0 || wb > LEN_W'(WORD_MAX))
            return LEN_W'(WORD_MAX);
        return wb;
    endfunction

    // Number of serial clocks needed to move a word of len bits.
    function automatic logic [LEN_W-1:0] slot_count(input logic [LEN_W-1:0] len,
                                                   input logic dual);
        return dual ? ((len + LEN_W'(1)) >> 1) : len;
    endfunction

    // Put the top bit of the len-bit word at the MSB of the shift register.
    function automatic logic [WORD_MAX-1:0] left_align(input logic [WORD_MAX-1:0] w,
                                                      input logic [LEN_W-1:0] len);
        return w << (LEN_W'(WORD_MAX) - len);
    endfunction

endpackage

// File: rtl/tfs_edge_sync.sv
`timescale 1ns/1ps
module tfs_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [2:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[1:0], async_in};
    end

    assign rise = pipe[1] & ~pipe[2];
endmodule

// File: rtl/tfs_shifter.sv
`timescale 1ns/1ps
module tfs_shifter
    import tfs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ld,
    input  logic [WORD_MAX-1:0] ld_word,
    input  logic [LEN_W-1:0]    ld_len,
    input  logic                ld_dual,
    input  logic                step,
    output logic [1:0]          lanes,
    output logic                last_slot
);
    logic [WORD_MAX-1:0] sh;
    logic [LEN_W-1:0]    left;
    logic                dual_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            left   <= '0;
            dual_q <= 1'b0;
        end else if (ld) begin
            sh     <= left_align(ld_word, ld_len);
            left   <= slot_count(ld_len, ld_dual);
            dual_q <= ld_dual;
        end else if (step) begin
            sh   <= dual_q ? (sh << 2) : (sh << 1);
            left <= left - LEN_W'(1);
        end
    end

    // Odd bit on wire 1, even bit on wire 0 when two wires are used.
    assign lanes     = dual_q ? {sh[WORD_MAX-1], sh[WORD_MAX-2]} : {1'b0, sh[WORD_MAX-1]};
    assign last_slot = (left == LEN_W'(1));
endmodule

// File: rtl/tfs_sequencer.sv
`timescale 1ns/1ps
module tfs_sequencer
    import tfs_pkg::*;
#(
    parameter int MAX_WORDS    = 8,
    parameter int FRAME_PIXELS = 32,
    parameter int CNT_W        = 8,
    parameter int QW           = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          te_mode,
    input  logic                          dual_lane,
    input  logic [LEN_W-1:0]              word_bits,
    input  logic [CNT_W-1:0]              lead_cycles,
    input  logic [CNT_W-1:0]              gap_cycles,
    input  logic [MAX_WORDS*WORD_MAX-1:0] cmd_words,
    input  logic [QW-1:0]                 cmd_count,
    input  logic                          cmd_start,
    input  logic                          te_rise,
    input  logic [WORD_MAX-1:0]           pix_data,
    input  logic                          pix_valid,
    input  logic                          last_slot,
    output tfs_state_e                    state,
    output logic                          ph,
    output logic                          ld,
    output logic [WORD_MAX-1:0]           ld_word,
    output logic [LEN_W-1:0]              ld_len,
    output logic                          ld_dual,
    output logic                          step,
    output logic                          pix_ready
);
    localparam int IW   = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
    localparam int RMAX = (FRAME_PIXELS > MAX_WORDS) ? FRAME_PIXELS : MAX_WORDS;
    localparam int RW   = $clog2(RMAX + 1);
    localparam int CW   = CNT_W + 1;

    tfs_xfer_t          cfg;
    logic [CNT_W-1:0]   gap_q;
    logic [CW-1:0]      cnt;
    logic [RW-1:0]      remaining;
    logic [IW-1:0]      idx;
    logic [RW-1:0]      cmd_n;
    logic               start_cmd;
    logic               start_frame;

    always_comb begin
        if (cmd_count > QW'(MAX_WORDS)) cmd_n = RW'(MAX_WORDS);
        else                            cmd_n = RW'(cmd_count);
    end

    assign start_cmd   = !te_mode && cmd_start && (cmd_count != '0);
    assign start_frame = te_mode && te_rise;

    assign pix_ready = (state == S_FETCH) && cfg.frame;
    assign ld        = (state == S_FETCH) && (cfg.frame ? pix_valid : 1'b1);
    assign ld_word   = cfg.frame ? pix_data : cmd_words[int'(idx)*WORD_MAX +: WORD_MAX];
    assign ld_len    = cfg.len;
    assign ld_dual   = cfg.dual;
    assign step      = (state == S_SHIFT) && ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ph        <= 1'b0;
            cnt       <= '0;
            remaining <= '0;
            idx       <= '0;
            cfg       <= '0;
            gap_q     <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    ph  <= 1'b0;
                    idx <= '0;
                    if (start_cmd || start_frame) begin
                        cfg.frame <= te_mode;
                        cfg.dual  <= te_mode & dual_lane;
                        cfg.len   <= te_mode ? LEN_W'(WORD_MAX) : clamp_len(word_bits);
                        gap_q     <= gap_cycles;
                        remaining <= te_mode ? RW'(FRAME_PIXELS) : cmd_n;
                        if (lead_cycles != '0) begin
                            state <= S_LEAD;
                            cnt   <= {lead_cycles, 1'b0};
                        end else begin
                            state <= S_FETCH;
                        end
                    end
                end
                S_LEAD: begin
                    if (cnt == CW'(1)) state <= S_FETCH;
                    else               cnt   <= cnt - CW'(1);
                end
                S_FETCH: begin
                    if (ld) begin
                        state <= S_SHIFT;
                        ph    <= 1'b0;
                        if (!cfg.frame) idx <= idx + IW'(1);
                    end
                end
                S_SHIFT: begin
                    ph <= ~ph;
                    if (ph && last_slot) begin
                        remaining <= remaining - RW'(1);
                        if (remaining == RW'(1)) begin
                            state <= S_TAIL;
                            cnt   <= CW'(2);
                        end else if (gap_q != '0) begin
                            state <= S_GAP;
                            cnt   <= {gap_q, 1'b0};
                        end else begin
                            state <= S_FETCH;
                        end
                    end
                end
                S_GAP: begin
                    if (cnt == CW'(1)) state <= S_FETCH;
                    else               cnt   <= cnt - CW'(1);
                end
                S_TAIL: begin
                    if (cnt == CW'(1)) state <= S_IDLE;
                    else               cnt   <= cnt - CW'(1);
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/te_frame_serializer.sv
`timescale 1ns/1ps
module te_frame_serializer
    import tfs_pkg::*;
#(
    parameter int MAX_WORDS    = 8,
    parameter int FRAME_PIXELS = 32,
    parameter int CNT_W        = 8,
    parameter int QW           = $clog2(MAX_WORDS) + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          te_mode,
    input  logic                          dual_lane,
    input  logic [LEN_W-1:0]              word_bits,
    input  logic [CNT_W-1:0]              lead_cycles,
    input  logic [CNT_W-1:0]              gap_cycles,
    input  logic [MAX_WORDS*WORD_MAX-1:0] cmd_words,
    input  logic [QW-1:0]                 cmd_count,
    input  logic                          cmd_start,
    input  logic                          te_in,
    input  logic [WORD_MAX-1:0]           pix_data,
    input  logic                          pix_valid,
    output logic                          pix_ready,
    output logic                          cs_n,
    output logic                          sclk,
    output logic [1:0]                    sdo,
    output logic                          busy
);
    tfs_state_e          state;
    logic                ph;
    logic                te_rise;
    logic                ld;
    logic [WORD_MAX-1:0] ld_word;
    logic [LEN_W-1:0]    ld_len;
    logic                ld_dual;
    logic                step;
    logic [1:0]          lanes;
    logic                last_slot;

    tfs_edge_sync u_te (
        .clk      (clk),
        .rst      (rst),
        .async_in (te_in),
        .rise     (te_rise)
    );

    tfs_sequencer #(
        .MAX_WORDS    (MAX_WORDS),
        .FRAME_PIXELS (FRAME_PIXELS),
        .CNT_W        (CNT_W),
        .QW           (QW)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .te_mode     (te_mode),
        .dual_lane   (dual_lane),
        .word_bits   (word_bits),
        .lead_cycles (lead_cycles),
        .gap_cycles  (gap_cycles),
        .cmd_words   (cmd_words),
        .cmd_count   (cmd_count),
        .cmd_start   (cmd_start),
        .te_rise     (te_rise),
        .pix_data    (pix_data),
        .pix_valid   (pix_valid),
        .last_slot   (last_slot),
        .state       (state),
        .ph          (ph),
        .ld          (ld),
        .ld_word     (ld_word),
        .ld_len      (ld_len),
        .ld_dual     (ld_dual),
        .step        (step),
        .pix_ready   (pix_ready)
    );

    tfs_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .ld        (ld),
        .ld_word   (ld_word),
        .ld_len    (ld_len),
        .ld_dual   (ld_dual),
        .step      (step),
        .lanes     (lanes),
        .last_slot (last_slot)
    );

    assign cs_n = (state == S_IDLE);
    assign busy = (state != S_IDLE);
    assign sclk = (state == S_SHIFT) && ph;
    assign sdo  = (state == S_SHIFT) ? lanes : 2'b00;
endmodule

// File: rtl/tfs_checker.sv
`timescale 1ns/1ps
module tfs_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic [1:0] sdo,
    input logic       pix_ready,
    input logic       pix_valid
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sclk && sdo == 2'b00 && !pix_ready));

    // R2
    sclk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk);

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdo));

    // R5
    open_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sclk);

    // R7
    close_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (!$past(sclk) && !$past(sclk, 2)));

    // R9
    accept_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_ready && pix_valid) |=> (!cs_n && !sclk));
endmodule

bind te_frame_serializer tfs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdo       (sdo),
    .pix_ready (pix_ready),
    .pix_valid (pix_valid)
);

// File: tb/te_frame_serializer_test.sv
`timescale 1ns/1ps
module te_frame_serializer_test;
    localparam int NPIX = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         te_mode = 1'b0;
    logic         dual_lane = 1'b0;
    logic [4:0]   word_bits = 5'd9;
    logic [7:0]   lead_cycles = 8'd2;
    logic [7:0]   gap_cycles = 8'd2;
    logic [127:0] cmd_words = '0;
    logic [3:0]   cmd_count = '0;
    logic         cmd_start = 1'b0;
    logic         te_in = 1'b0;
    logic [15:0]  pix_data;
    logic         pix_valid;
    logic         pix_ready;
    logic         cs_n;
    logic         sclk;
    logic [1:0]   sdo;
    logic         busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pidx   = 0;
    bit stall_en = 1'b0;

    logic [1:0] cap  [0:4095];
    int         capc [0:4095];
    int         nslot = 0;
    int         falls = 0;
    int         cs_fall = 0;
    int         cs_rise = 0;
    logic       cs_prev = 1'b1;

    te_frame_serializer #(.FRAME_PIXELS(NPIX)) uut (
        .clk(clk), .rst(rst), .te_mode(te_mode), .dual_lane(dual_lane),
        .word_bits(word_bits), .lead_cycles(lead_cycles), .gap_cycles(gap_cycles),
        .cmd_words(cmd_words), .cmd_count(cmd_count), .cmd_start(cmd_start),
        .te_in(te_in), .pix_data(pix_data), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .busy(busy)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] pxv(input int i);
        logic [15:0] v;
        v = 16'(i) * 16'h1F3B;
        return v ^ 16'hC3A5;
    endfunction

    assign pix_data  = pxv(pidx);
    assign pix_valid = !stall_en || cyc[1];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && pix_ready && pix_valid) pidx <= pidx + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk && nslot < 4096) begin
                cap[nslot]  = sdo;
                capc[nslot] = cyc;
                nslot++;
            end
            if (!cs_n && cs_prev) begin
                cs_fall = cyc;
                falls++;
            end
            if (cs_n && !cs_prev) cs_rise = cyc;
            cs_prev = cs_n;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    function automatic logic [15:0] grab(input int s, input int n, input bit two);
        logic [15:0] w;
        w = '0;
        for (int k = 0; k < n; k++)
            w = two ? {w[13:0], cap[s+k]} : {w[14:0], cap[s+k][0]};
        return w;
    endfunction

    function automatic bit wire1_quiet(input int n);
        for (int k = 0; k < n; k++)
            if (cap[k][1] !== 1'b0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic wait_done(input int f0, input int lim);
        int k;
        k = 0;
        while (falls == f0 && k < lim) begin tick(1); k++; end
        while (!cs_n && k < lim) begin tick(1); k++; end
        tick(1);
    endtask

    task automatic run_cmd();
        int f0;
        nslot = 0;
        f0 = falls;
        tick(1);
        cmd_start = 1'b1;
        tick(1);
        cmd_start = 1'b0;
        wait_done(f0, 3000);
    endtask

    task automatic t_reset();
        check(cs_n == 1'b1,     "R1", "cs_n after reset", int'(cs_n), 1);
        check(sclk == 1'b0,     "R1", "sclk after reset", int'(sclk), 0);
        check(sdo == 2'b00,     "R1", "sdo after reset", int'(sdo), 0);
        check(busy == 1'b0,     "R1", "busy after reset", int'(busy), 0);
        check(pix_ready == 1'b0,"R1", "pix_ready after reset", int'(pix_ready), 0);
    endtask

    // R2 R5 R6 R7: nine-bit command then two parameters
    task automatic t_cmd_seq();
        te_mode = 0; word_bits = 5'd9; lead_cycles = 8'd2; gap_cycles = 8'd2;
        cmd_words = '0;
        cmd_words[15:0]  = 16'h00DA;
        cmd_words[31:16] = 16'h01FF;
        cmd_words[47:32] = 16'h01AB;
        cmd_count = 4'd3;
        run_cmd();
        check(nslot == 27, "R2", "slot count", nslot, 27);
        check(grab(0, 9, 0) == 16'h00DA,  "R2", "command word", int'(grab(0, 9, 0)), 16'h00DA);
        check(cap[0][0] == 1'b0,          "R2", "command flag bit", int'(cap[0][0]), 0);
        check(grab(9, 9, 0) == 16'h01FF,  "R2", "parameter word 1", int'(grab(9, 9, 0)), 16'h01FF);
        check(cap[9][0] == 1'b1,          "R2", "parameter flag bit", int'(cap[9][0]), 1);
        check(grab(18, 9, 0) == 16'h01AB, "R2", "parameter word 2", int'(grab(18, 9, 0)), 16'h01AB);
        check(wire1_quiet(27),            "R2", "wire 1 quiet", 0, 0);
        check(capc[0] - cs_fall == 6,     "R5", "lead spacing D=2", capc[0] - cs_fall, 6);
        check(capc[1] - capc[0] == 2,     "R6", "bit spacing", capc[1] - capc[0], 2);
        check(capc[9] - capc[8] == 7,     "R6", "word spacing W=2", capc[9] - capc[8], 7);
        check(cs_rise - capc[26] == 3,    "R7", "cs release", cs_rise - capc[26], 3);
    endtask

    // R3: word length clamping
    task automatic t_len_clamp();
        lead_cycles = 8'd0; gap_cycles = 8'd0;
        cmd_words = '0;
        cmd_words[15:0] = 16'hA5C3;
        cmd_count = 4'd1;
        word_bits = 5'd0;
        run_cmd();
        check(nslot == 16, "R3", "length 0 slots", nslot, 16);
        check(grab(0, 16, 0) == 16'hA5C3, "R3", "length 0 word", int'(grab(0, 16, 0)), 16'hA5C3);
        word_bits = 5'd20;
        run_cmd();
        check(nslot == 16, "R3", "length 20 slots", nslot, 16);
        word_bits = 5'd5;
        run_cmd();
        check(nslot == 5, "R3", "length 5 slots", nslot, 5);
        check(grab(0, 5, 0) == 16'h0003, "R3", "length 5 word", int'(grab(0, 5, 0)), 16'h0003);
    endtask

    // R4 R5 R6: word count limits, zero lead and gap
    task automatic t_count();
        int f0;
        word_bits = 5'd8; lead_cycles = 8'd0; gap_cycles = 8'd0;
        for (int i = 0; i < 8; i++) cmd_words[i*16 +: 16] = 16'(8'h30 + i);
        cmd_count = 4'd0;
        f0 = falls;
        tick(1); cmd_start = 1'b1; tick(1); cmd_start = 1'b0;
        tick(40);
        check(falls == f0 && cs_n, "R4", "count 0 starts nothing", falls - f0, 0);
        cmd_count = 4'd12;
        run_cmd();
        check(nslot == 64, "R4", "count 12 capped slots", nslot, 64);
        check(grab(56, 8, 0) == 16'h0037, "R4", "eighth word", int'(grab(56, 8, 0)), 16'h0037);
        check(capc[0] - cs_fall == 2, "R5", "lead spacing D=0", capc[0] - cs_fall, 2);
        check(capc[8] - capc[7] == 3, "R6", "word spacing W=0", capc[8] - capc[7], 3);
        check(cs_rise - capc[63] == 3, "R7", "cs release", cs_rise - capc[63], 3);
    endtask

    // R8: cmd_start ignored in frame mode
    task automatic t_te_blocks_cmd();
        int f0;
        te_mode = 1'b1; te_in = 1'b0; cmd_count = 4'd2;
        f0 = falls;
        tick(1); cmd_start = 1'b1; tick(1); cmd_start = 1'b0;
        tick(40);
        check(falls == f0 && cs_n, "R8", "cmd_start in frame mode", falls - f0, 0);
    endtask

    task automatic t_frame(input bit two, input bit stall, input string req);
        int f0, p0, per, s;
        te_mode = 1'b1; dual_lane = two; stall_en = stall;
        lead_cycles = 8'd1; gap_cycles = 8'd1;
        nslot = 0; f0 = falls; p0 = pidx;
        tick(1);
        te_in = 1'b1;
        wait_done(f0, 8000);
        tick(40);
        per = two ? 8 : 16;
        check(falls == f0 + 1, "R8", "one frame per edge with te held high", falls - f0, 1);
        check(nslot == NPIX * per, req, "frame slot count", nslot, NPIX * per);
        for (int i = 0; i < NPIX; i++) begin
            s = i * per;
            check(grab(s, per, two) == pxv(p0 + i), req, "pixel value",
                  int'(grab(s, per, two)), int'(pxv(p0 + i)));
        end
        check(pidx - p0 == NPIX, "R9", "pixels taken", pidx - p0, NPIX);
        if (!two) check(wire1_quiet(nslot), "R9", "wire 1 quiet single", 0, 0);
        te_in = 1'b0; stall_en = 1'b0;
        tick(5);
    endtask

    // R11: second edge during frame ignored
    task automatic t_te_ignore();
        int f0, k;
        te_mode = 1'b1; dual_lane = 1'b0; lead_cycles = 8'd1; gap_cycles = 8'd1;
        nslot = 0; f0 = falls;
        tick(1); te_in = 1'b1; tick(4); te_in = 1'b0;
        k = 0;
        while (cs_n && k < 50) begin tick(1); k++; end
        tick(30);
        te_in = 1'b1; tick(4); te_in = 1'b0;
        wait_done(f0, 8000);
        tick(80);
        check(falls == f0 + 1, "R11", "frames after mid-frame edge", falls - f0, 1);
        check(nslot == NPIX * 16, "R11", "slots after mid-frame edge", nslot, NPIX * 16);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_cmd_seq();
        t_len_clamp();
        t_count();
        t_te_blocks_cmd();
        t_frame(1'b0, 1'b0, "R9");
        t_frame(1'b1, 1'b0, "R10");
        t_frame(1'b1, 1'b1, "R12");
        t_frame(1'b0, 1'b1, "R12");
        t_te_ignore();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule